// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

A register-mapped timer with a parameterised number of identical channels (four by default). Each channel holds a 64-bit interval and a 64-bit down-counter. The interval and the counter are each visible as two 32-bit words. Each channel also has a control word that sets run/stop, a load strobe, a power-of-two prescaler and the choice between a one-shot and a periodic run.

A timer-clock enable input, `tick_en_i`, marks the cycles that count as timer-clock cycles. When a channel expires it sets its bit in a shared pending register. A shared mask register decides which pending bits reach the single interrupt line, and software clears pending bits by writing ones to them. Software reads a coherent 64-bit count by reading the low word first, because that read captures the high word.

The register port is synchronous. A write takes effect at the clock edge in which `reg_we_i` is high. Read data appears on `reg_rdata_o` one cycle after `reg_re_i`.

Top module: `dcount_timer`

## Requirements
- R1: After reset, every control word, interval, count, the mask register, the pending register, `reg_rdata_o` and `irq_o` are zero.
- R2: Shared registers sit at fixed offsets: mask at 0x00 and pending at 0x04, with bit n belonging to channel n. Each channel n has five registers: control at 32n+0x10, interval low at 32n+0x14, interval high at 32n+0x18, count low at 32n+0x1C and count high at 32n+0x20. Interval words read back what was written.
- R3: Writing control with bit 0 (run) and bit 1 (load) both set copies the interval into the counter and starts the channel. Bit 1 always reads back as 0.
- R4: A running channel decrements once per prescaled tick. Control bits 6:4 hold p, and a tick occurs on every 2^p-th timer-clock cycle, counted from the load. With p=2, 40 timer-clock cycles give 10 decrements.
- R5: In periodic mode (control bit 7 = 0), a tick that finds the count at 1 or 0 is an expiry and reloads the interval. The period is therefore the interval value in ticks.
- R6: In one-shot mode (control bit 7 = 1), an expiry leaves the count at 0, clears the run bit and stops the channel.
- R7: An expiry sets the channel's pending bit. Writing 1 to a pending bit clears it. When an expiry and a clear of the same bit fall in one cycle, the bit stays set.
- R8: `irq_o` is high exactly when some channel has both its pending bit and its mask bit set.
- R9: After run is cleared, the counter still decrements on the next 2 timer-clock cycles (at prescale 0) and then holds its value.
- R10: A read of count low returns the live low word and captures the high word. A later read of count high returns the captured value.
- R11: Writes to the count words are ignored. Reads from unmapped offsets return 0.
- R12: Writing control with run set and load clear resumes counting from the held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | High in cycles that count as timer-clock cycles |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| irq_o | output | 1 | Interrupt, the OR of pending bits that are masked in |

## Verification
The conflict of interest is an expiry that sets a pending bit in the same cycle that software writes a 1 to clear that bit. The bench loads a channel with interval 1 while `tick_en_i` is low. It then asserts `tick_en_i` and the pending-register write in the same cycle. The bit must read back as set, and a second clear on its own must then remove it. The stop delay is also timed exactly, because the bench gates `tick_en_i` itself: the count must fall by exactly two and then hold.

// File: rtl/dcount_timer_pkg.sv
package dcount_timer_pkg;
  localparam int unsigned PSC_W        = 3;
  localparam int unsigned CTRL_EN      = 0;
  localparam int unsigned CTRL_RLD     = 1;
  localparam int unsigned CTRL_PSC_LSB = 4;
  localparam int unsigned CTRL_OS      = 7;

  localparam int unsigned OFS_IEN      = 'h00;
  localparam int unsigned OFS_STS      = 'h04;
  localparam int unsigned CH_STRIDE    = 'h20;
  localparam int unsigned OFS_CTRL     = 'h10;
  localparam int unsigned OFS_IVL_LO   = 'h14;
  localparam int unsigned OFS_IVL_HI   = 'h18;
  localparam int unsigned OFS_CNT_LO   = 'h1c;
  localparam int unsigned OFS_CNT_HI   = 'h20;
endpackage

// File: rtl/dcount_prescale.sv
module dcount_prescale #(
  parameter int unsigned PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] pc_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(psc_i));
  end

  assign tick_o = tick_en_i & ((pc_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= '0;
    else if (clr_i)     pc_q <= '0;
    else if (tick_en_i) pc_q <= pc_q + DIV_W'(1);
  end

  // R4: with a divider above 1, two ticks never come back to back
  a_r4_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && psc_i != '0) |=> (!tick_o || psc_i == '0));
endmodule

// File: rtl/dcount_channel.sv
module dcount_channel
  import dcount_timer_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STOP_CYC = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_en_i,
  input  logic                ctrl_we_i,
  input  logic                ivl_lo_we_i,
  input  logic                ivl_hi_we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   ctrl_o,
  output logic [2*DATA_W-1:0] ivl_o,
  output logic [2*DATA_W-1:0] cnt_o,
  output logic                expire_o
);
  localparam int unsigned CNT_W  = 2 * DATA_W;
  localparam int unsigned STOP_W = $clog2(STOP_CYC + 1);

  logic              en_q, os_q;
  logic [PSC_W-1:0]  psc_q;
  logic [STOP_W-1:0] stop_q;
  logic [CNT_W-1:0]  cnt_q, ivl_q;
  logic              active, wr_load, ptick, last;

  assign active  = en_q | (stop_q != '0);
  assign wr_load = ctrl_we_i & wdata_i[CTRL_EN] & wdata_i[CTRL_RLD];
  assign last    = (cnt_q[CNT_W-1:1] == '0);

  dcount_prescale #(.PSC_W(PSC_W)) i_prescale (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_en_i(tick_en_i & active & ~ctrl_we_i),
    .clr_i    (wr_load),
    .psc_i    (psc_q),
    .tick_o   (ptick)
  );

  assign expire_o = ptick & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      os_q   <= 1'b0;
      psc_q  <= '0;
      stop_q <= '0;
      cnt_q  <= '0;
      ivl_q  <= '0;
    end else begin
      if (ivl_lo_we_i) ivl_q[DATA_W-1:0]     <= wdata_i;
      if (ivl_hi_we_i) ivl_q[CNT_W-1:DATA_W] <= wdata_i;
      if (ctrl_we_i) begin
        psc_q <= wdata_i[CTRL_PSC_LSB +: PSC_W];
        os_q  <= wdata_i[CTRL_OS];
        en_q  <= wdata_i[CTRL_EN];
        if (wr_load) cnt_q <= ivl_q;
        if (wdata_i[CTRL_EN]) stop_q <= '0;
        else if (en_q)        stop_q <= STOP_W'(STOP_CYC);  // drain window
      end else begin
        if (tick_en_i && stop_q != '0) stop_q <= stop_q - STOP_W'(1);
        if (ptick) begin
          if (last) begin
            if (os_q) begin
              cnt_q  <= '0;
              en_q   <= 1'b0;
              stop_q <= '0;
            end else begin
              cnt_q <= ivl_q;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
      end
    end
  end

  always_comb begin
    ctrl_o                          = '0;
    ctrl_o[CTRL_EN]                 = en_q;
    ctrl_o[CTRL_PSC_LSB +: PSC_W]   = psc_q;
    ctrl_o[CTRL_OS]                 = os_q;
  end

  assign ivl_o = ivl_q;
  assign cnt_o = cnt_q;

  a_r3_load_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_load |=> (cnt_q == $past(ivl_q)) && en_q);
  a_r5_periodic_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !os_q) |=> cnt_q == $past(ivl_q));
  a_r6_oneshot_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && os_q) |=> (cnt_q == '0) && !en_q);
  a_r9_frozen_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !ctrl_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import dcount_timer_pkg::*;
#(
  parameter int unsigned N_CH     = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STOP_CYC = 2,
  parameter int unsigned ADDR_W   = $clog2(CH_STRIDE * N_CH + OFS_CNT_HI + 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [N_CH-1:0]   ien_q, sts_q, expire, sts_clr;
  logic [N_CH-1:0]   sel_ctrl, sel_ivl_lo, sel_ivl_hi, sel_cnt_lo, sel_cnt_hi;
  logic [DATA_W-1:0] ctrl_rd  [N_CH];
  logic [CNT_W-1:0]  ivl_rd   [N_CH];
  logic [CNT_W-1:0]  cnt_rd   [N_CH];
  logic [DATA_W-1:0] shadow_q [N_CH];
  logic [DATA_W-1:0] rd_val, rdata_q;
  logic              sel_ien, sel_sts;

  assign sel_ien = (reg_addr_i == ADDR_W'(OFS_IEN));
  assign sel_sts = (reg_addr_i == ADDR_W'(OFS_STS));
  assign sts_clr = (reg_we_i && sel_sts) ? reg_wdata_i[N_CH-1:0] : '0;

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    localparam int unsigned BASE = CH_STRIDE * n;
    assign sel_ctrl[n]   = (reg_addr_i == ADDR_W'(BASE + OFS_CTRL));
    assign sel_ivl_lo[n] = (reg_addr_i == ADDR_W'(BASE + OFS_IVL_LO));
    assign sel_ivl_hi[n] = (reg_addr_i == ADDR_W'(BASE + OFS_IVL_HI));
    assign sel_cnt_lo[n] = (reg_addr_i == ADDR_W'(BASE + OFS_CNT_LO));
    assign sel_cnt_hi[n] = (reg_addr_i == ADDR_W'(BASE + OFS_CNT_HI));

    dcount_channel #(.DATA_W(DATA_W), .STOP_CYC(STOP_CYC)) i_channel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_en_i  (tick_en_i),
      .ctrl_we_i  (reg_we_i & sel_ctrl[n]),
      .ivl_lo_we_i(reg_we_i & sel_ivl_lo[n]),
      .ivl_hi_we_i(reg_we_i & sel_ivl_hi[n]),
      .wdata_i    (reg_wdata_i),
      .ctrl_o     (ctrl_rd[n]),
      .ivl_o      (ivl_rd[n]),
      .cnt_o      (cnt_rd[n]),
      .expire_o   (expire[n])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       shadow_q[n] <= '0;
      else if (reg_re_i && sel_cnt_lo[n]) shadow_q[n] <= cnt_rd[n][CNT_W-1:DATA_W];
    end

    // R7: expiry wins over a same-cycle clear
    a_r7_pending_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire[n] |=> sts_q[n]);
    a_r7_pending_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_clr[n] && !expire[n]) |=> !sts_q[n]);
    a_r10_shadow_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_re_i && sel_cnt_lo[n]) |=> shadow_q[n] == $past(cnt_rd[n][CNT_W-1:DATA_W]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      sts_q <= '0;
    end else begin
      if (reg_we_i && sel_ien) ien_q <= reg_wdata_i[N_CH-1:0];
      sts_q <= (sts_q & ~sts_clr) | expire;
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel_ien) rd_val[N_CH-1:0] = ien_q;
    if (sel_sts) rd_val[N_CH-1:0] = sts_q;
    for (int n = 0; n < N_CH; n++) begin
      if (sel_ctrl[n])   rd_val = ctrl_rd[n];
      if (sel_ivl_lo[n]) rd_val = ivl_rd[n][DATA_W-1:0];
      if (sel_ivl_hi[n]) rd_val = ivl_rd[n][CNT_W-1:DATA_W];
      if (sel_cnt_lo[n]) rd_val = cnt_rd[n][DATA_W-1:0];
      if (sel_cnt_hi[n]) rd_val = shadow_q[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_val;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = |(sts_q & ien_q);

  a_r8_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sts_q != '0) && (ien_q != '0));
endmodule

// File: tb/test_dcount_timer.sv
module test_dcount_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_en_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_re_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  dcount_timer i_dcount_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_en_i(tick_en_i),
    .reg_we_i(reg_we_i), .reg_re_i(reg_re_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] a_ctrl(int n);   return 8'(32*n + 'h10); endfunction
  function automatic logic [7:0] a_ivl_lo(int n); return 8'(32*n + 'h14); endfunction
  function automatic logic [7:0] a_ivl_hi(int n); return 8'(32*n + 'h18); endfunction
  function automatic logic [7:0] a_cnt_lo(int n); return 8'(32*n + 'h1c); endfunction
  function automatic logic [7:0] a_cnt_hi(int n); return 8'(32*n + 'h20); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_addr_i = a;
    @(negedge clk_i);
    reg_re_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic ticks(int n);
    @(negedge clk_i);
    tick_en_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_en_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 rdata", reg_rdata_o, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
    rd(a_ctrl(0), d);   check("R1 ctrl0", d, 0);
    rd(a_cnt_lo(1), d); check("R1 cnt1", d, 0);
    rd(a_ivl_hi(3), d); check("R1 ivl3", d, 0);
    rd(8'h00, d);       check("R1 mask", d, 0);
    rd(8'h04, d);       check("R1 pending", d, 0);
  endtask

  task automatic t_load;
    logic [31:0] d;
    wr(a_ivl_lo(1), 32'h100);
    wr(a_ivl_hi(1), 32'h2);
    rd(a_ivl_lo(1), d); check("R2 ivl lo readback", d, 32'h100);
    wr(a_ctrl(1), 32'h3);
    rd(a_cnt_lo(1), d); check("R3 count lo loaded", d, 32'h100);
    rd(a_cnt_hi(1), d); check("R3 count hi loaded", d, 32'h2);
    rd(a_ctrl(1), d);   check("R3 load bit reads 0", d, 32'h1);
  endtask

  task automatic t_prescale;
    logic [31:0] d;
    wr(a_ivl_lo(1), 32'd1000);
    wr(a_ivl_hi(1), 32'd0);
    wr(a_ctrl(1), 32'h23);
    ticks(40);
    rd(a_cnt_lo(1), d); check("R4 div4 after 40", d, 32'd990);
    ticks(3);
    rd(a_cnt_lo(1), d); check("R4 no tick before 4th", d, 32'd990);
    ticks(1);
    rd(a_cnt_lo(1), d); check("R4 tick on 4th", d, 32'd989);
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    wr(a_ivl_lo(2), 32'd5);
    wr(a_ctrl(2), 32'h3);
    ticks(12);
    rd(a_cnt_lo(2), d); check("R5 periodic count", d, 32'd3);
    rd(8'h04, d);       check("R7 pending ch2", d & 32'h4, 32'h4);
  endtask

  task automatic t_oneshot;
    logic [31:0] d;
    wr(a_ivl_lo(3), 32'd3);
    wr(a_ctrl(3), 32'h83);
    ticks(10);
    rd(a_cnt_lo(3), d); check("R6 oneshot count", d, 0);
    rd(a_ctrl(3), d);   check("R6 run cleared", d, 32'h80);
    rd(8'h04, d);       check("R7 pending ch3", d & 32'h8, 32'h8);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    check("R8 irq masked off", {31'b0, irq_o}, 0);
    wr(8'h00, 32'h8);
    check("R8 irq on", {31'b0, irq_o}, 1);
    wr(8'h04, 32'h8);
    check("R8 irq after clear", {31'b0, irq_o}, 0);
    wr(8'h04, 32'h4);
    rd(8'h04, d); check("R7 w1c clears", d, 0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    wr(a_ivl_lo(0), 32'd1);
    wr(a_ctrl(0), 32'h3);
    @(negedge clk_i);
    tick_en_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 8'h04; reg_wdata_i = 32'h1;
    @(negedge clk_i);
    tick_en_i = 1'b0; reg_we_i = 1'b0;
    rd(8'h04, d); check("R7 set wins over clear", d & 32'h1, 32'h1);
    wr(8'h04, 32'h1);
    rd(8'h04, d); check("R7 lone clear", d & 32'h1, 0);
    wr(a_ctrl(0), 32'h0);
  endtask

  task automatic t_drain;
    logic [31:0] d;
    wr(a_ivl_lo(1), 32'd500);
    wr(a_ctrl(1), 32'h3);
    ticks(4);
    rd(a_cnt_lo(1), d); check("R9 running", d, 32'd496);
    wr(a_ctrl(1), 32'h0);
    ticks(10);
    rd(a_cnt_lo(1), d); check("R9 two more then halt", d, 32'd494);
    ticks(5);
    rd(a_cnt_lo(1), d); check("R9 stays halted", d, 32'd494);
    wr(a_ctrl(1), 32'h1);
    ticks(3);
    rd(a_cnt_lo(1), d); check("R12 resume without load", d, 32'd491);
  endtask

  task automatic t_coherent;
    logic [31:0] d;
    wr(a_ivl_lo(2), 32'd1);
    wr(a_ivl_hi(2), 32'd1);
    wr(a_ctrl(2), 32'h3);
    rd(a_cnt_lo(2), d); check("R10 low word", d, 32'h1);
    ticks(2);
    rd(a_cnt_hi(2), d); check("R10 captured high", d, 32'h1);
    rd(a_cnt_lo(2), d); check("R10 new low", d, 32'hFFFF_FFFF);
    rd(a_cnt_hi(2), d); check("R10 new high", d, 32'h0);
  endtask

  task automatic t_ignore;
    logic [31:0] d;
    wr(a_cnt_lo(3), 32'h55);
    wr(a_cnt_hi(3), 32'h66);
    rd(a_cnt_lo(3), d); check("R11 count lo write ignored", d, 0);
    rd(a_cnt_hi(3), d); check("R11 count hi write ignored", d, 0);
    rd(8'h08, d);       check("R11 unmapped reads 0", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load();
    t_prescale();
    t_periodic();
    t_oneshot();
    t_irq();
    t_collision();
    t_drain();
    t_coherent();
    t_ignore();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule